// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire bus. A bit-slot engine underneath it turns the line activity into three kinds of one-cycle events: a bus reset, a received bit from a master write slot, and a request for the slave's answer in a master read slot. After every bus reset the block gathers an 8-bit command and then runs the selected addressing procedure against its 64-bit identity code.

The identity code is built inside the block. A fixed family byte sits at the bottom, a 48-bit serial number supplied on a port sits above it, and a CRC computed over those 56 bits fills the top byte. When addressing succeeds, the block raises a one-cycle select strobe so the function-command layer above may take over. A successful read, match or skip counts as success. A search pass never leads to selection. The function layer acts only on that strobe, so function traffic that does not follow a valid command since the last reset goes nowhere.

Top module: `swire_rom_layer`

## Requirements
- R1: The identity code holds 10h in bits 7:0, `serial_no` in bits 55:8, and in bits 63:56 a CRC of bits 55:0. The CRC uses the polynomial x^8+x^5+x^4+1, starts from zero, and takes its input bits from bit 0 upward.
- R2: After `rst_n` is released, the block ignores all received bits until the first `bus_reset`. `tx_bit` reads 1 (line released) and `sel_strobe` reads 0 at that point.
- R3: After a bus reset, the next 8 received bits form the command, first bit in bit 0. The codes are 33h read, 55h match, CCh skip, F0h search and ECh alarm search. Any other code makes the block ignore everything until the next bus reset.
- R4: For the read command, 64 read slots return identity bits 0 to 63 in that order. `sel_strobe` pulses in the cycle after the 64th slot.
- R5: For the match command, 64 received bits are compared with identity bits 0 to 63. If all of them agree, `sel_strobe` pulses in the cycle after the 64th bit. After the first disagreement, `sel_strobe` stays low and `tx_bit` stays 1 until the next bus reset.
- R6: For the skip command, `sel_strobe` pulses in the cycle after the 8th command bit.
- R7: For a search, each identity bit takes three slots: a read slot that returns the bit, a read slot that returns its complement, and a received bit carrying the master's choice. If the choice differs from the block's own bit, `tx_bit` stays 1 until the next bus reset. A search never raises `sel_strobe`, and the block returns to waiting for a bus reset after bit 63.
- R8: The alarm search behaves exactly like R7 if `alarm_flag` is 1 when the command byte completes. Otherwise the block keeps `tx_bit` at 1 until the next bus reset.
- R9: A `bus_reset` at any point abandons the current command and restarts command collection.
- R10: `sel_strobe` lasts exactly one cycle and occurs at most once per bus reset.
- R11: Once selected, or while ignoring traffic, the block answers read slots with 1 and disregards received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | One-cycle bus reset event from the slot engine |
| rx_valid | input | 1 | One-cycle event: a bit written by the master is available |
| rx_bit | input | 1 | Value of the written bit |
| tx_req | input | 1 | One-cycle event: the master's read slot consumes `tx_bit` |
| alarm_flag | input | 1 | Alarm condition from the measurement logic |
| serial_no | input | 48 | Serial number field of the identity |
| tx_bit | output | 1 | Bit the slave answers with in a read slot; 1 means released |
| sel_strobe | output | 1 | One-cycle pulse: addressing succeeded, function layer may proceed |

## Verification
The hardest situation to reach is a slave dropping out in the middle of a search. Each bit position takes a three-slot exchange, so the bench has to track the exchange for every bit and then deliberately choose the opposite of the slave's bit at a chosen position. The tasks therefore act as a full search master. They read the bit and its complement, check both, and then send either the agreeing bit or a forced disagreement at a given index. After that they confirm that both answer slots read as released. The same master, driven with the alarm flag clear and set, shows the conditional silence of the alarm search.

// File: rtl/swire_rom_pkg.sv
package swire_rom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_ALARM  = 8'hEC;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_READ,
        CK_MATCH,
        CK_SKIP,
        CK_SEARCH,
        CK_ALARM
    } rom_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_SEL
    } rom_state_e;

endpackage

// File: rtl/swire_id_gen.sv
module swire_id_gen #(
    parameter int          ID_BITS = 64,
    parameter logic [7:0]  FAMILY  = 8'h10
) (
    input  logic [ID_BITS-17:0] serial_no,
    output logic [ID_BITS-1:0]  id_code
);
    localparam int BODY_W = ID_BITS - 8;

    logic [BODY_W-1:0] body;
    logic [7:0]        crc;
    logic              fb;

    assign body = {serial_no, FAMILY};

    // R1: reflected CRC-8 (x^8+x^5+x^4+1), fed from bit 0 upward, seed zero
    always_comb begin
        crc = '0;
        fb  = 1'b0;
        for (int i = 0; i < BODY_W; i++) begin
            fb  = crc[0] ^ body[i];
            crc = {1'b0, crc[7:1]} ^ (fb ? 8'h8C : 8'h00);
        end
    end

    assign id_code = {crc, body};

endmodule

// File: rtl/swire_cmd_decode.sv
module swire_cmd_decode
    import swire_rom_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output rom_cmd_e         kind
);
    always_comb begin
        case (code)
            OP_READ:   kind = CK_READ;
            OP_MATCH:  kind = CK_MATCH;
            OP_SKIP:   kind = CK_SKIP;
            OP_SEARCH: kind = CK_SEARCH;
            OP_ALARM:  kind = CK_ALARM;
            default:   kind = CK_NONE;
        endcase
    end

endmodule

// File: rtl/swire_rom_layer.sv
module swire_rom_layer
    import swire_rom_pkg::*;
#(
    parameter int         ID_BITS = 64,
    parameter logic [7:0] FAMILY  = 8'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_reset,
    input  logic                rx_valid,
    input  logic                rx_bit,
    input  logic                tx_req,
    input  logic                alarm_flag,
    input  logic [ID_BITS-17:0] serial_no,
    output logic                tx_bit,
    output logic                sel_strobe
);
    localparam int CNT_W = $clog2(ID_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ID_BITS - 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);

    typedef struct packed {
        rom_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       phase;
        logic [CMD_W-1:0] sr;
        logic             strobe;
    } regs_t;

    regs_t q, d;

    logic [ID_BITS-1:0] id_code;
    logic [CMD_W-1:0]   sr_next;
    rom_cmd_e           kind;
    logic               id_bit;
    logic               at_last;

    swire_id_gen #(.ID_BITS(ID_BITS), .FAMILY(FAMILY)) u_id (
        .serial_no (serial_no),
        .id_code   (id_code)
    );

    assign sr_next = {rx_bit, q.sr[CMD_W-1:1]};

    swire_cmd_decode u_dec (
        .code (sr_next),
        .kind (kind)
    );

    assign id_bit  = id_code[q.cnt];
    assign at_last = (q.cnt == CNT_LAST);

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        if (bus_reset) begin
            d.state = ST_CMD;
            d.cnt   = '0;
            d.phase = 2'd0;
            d.sr    = '0;
        end else begin
            case (q.state)
                ST_CMD: if (rx_valid) begin
                    d.sr  = sr_next;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CMD_LAST) begin
                        d.cnt   = '0;
                        d.phase = 2'd0;
                        case (kind)
                            CK_READ:   d.state = ST_READ;
                            CK_MATCH:  d.state = ST_MATCH;
                            CK_SKIP: begin
                                d.state  = ST_SEL;
                                d.strobe = 1'b1;
                            end
                            CK_SEARCH: d.state = ST_SRCH;
                            CK_ALARM:  d.state = alarm_flag ? ST_SRCH : ST_IDLE;
                            default:   d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: if (tx_req) begin
                    if (at_last) begin
                        d.state  = ST_SEL;
                        d.strobe = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_MATCH: if (rx_valid) begin
                    if (rx_bit != id_bit) begin
                        d.state = ST_IDLE;
                    end else if (at_last) begin
                        d.state  = ST_SEL;
                        d.strobe = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_SRCH: begin
                    if (q.phase == 2'd2) begin
                        if (rx_valid) begin
                            if (rx_bit != id_bit || at_last) begin
                                d.state = ST_IDLE;
                            end else begin
                                d.cnt   = q.cnt + 1'b1;
                                d.phase = 2'd0;
                            end
                        end
                    end else if (tx_req) begin
                        d.phase = q.phase + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.cnt    <= '0;
            q.phase  <= 2'd0;
            q.sr     <= '0;
            q.strobe <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.state)
            ST_READ: tx_bit = id_bit;
            ST_SRCH: tx_bit = (q.phase == 2'd0) ? id_bit :
                              (q.phase == 2'd1) ? ~id_bit : 1'b1;
            default: tx_bit = 1'b1;
        endcase
    end

    assign sel_strobe = q.strobe;

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |=> !sel_strobe);

    a_r10_strobe_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |-> $past(rx_valid || tx_req));

    a_r9_reset_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (q.state == ST_CMD && q.cnt == '0 && !sel_strobe));

    a_r7_complement_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SRCH && q.phase == 2'd1 &&
         $past(q.state) == ST_SRCH && $past(q.phase) == 2'd0)
        |-> (tx_bit != $past(tx_bit)));

    a_r11_released_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE || q.state == ST_SEL) |-> tx_bit);

    a_r2_no_strobe_without_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !bus_reset) |=> !sel_strobe);

endmodule

// File: tb/sim_swire_rom_layer.sv
module sim_swire_rom_layer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_req = 1'b0;
    logic        alarm_flag = 1'b0;
    logic [47:0] serial_no = 48'h00A1_B2C3_D4E5;
    logic        tx_bit;
    logic        sel_strobe;

    int total = 0;
    int bad   = 0;
    logic [63:0] exp_id;

    always #5 clk = ~clk;

    swire_rom_layer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .tx_req     (tx_req),
        .alarm_flag (alarm_flag),
        .serial_no  (serial_no),
        .tx_bit     (tx_bit),
        .sel_strobe (sel_strobe)
    );

    function automatic logic [63:0] make_id(input logic [47:0] s);
        logic [55:0] b;
        logic [7:0]  c;
        logic        f;
        b = {s, 8'h10};
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            f = c[0] ^ b[i];
            c = c >> 1;
            if (f) c = c ^ 8'h8C;
        end
        return {c, b};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk) bus_reset = 1'b1;
        @(negedge clk) bus_reset = 1'b0;
    endtask

    task automatic put_bit(input logic b, output logic stb);
        @(negedge clk) begin rx_valid = 1'b1; rx_bit = b; end
        @(negedge clk) rx_valid = 1'b0;
        stb = sel_strobe;
    endtask

    task automatic get_bit(output logic b, output logic stb);
        @(negedge clk) begin b = tx_bit; tx_req = 1'b1; end
        @(negedge clk) tx_req = 1'b0;
        stb = sel_strobe;
    endtask

    task automatic put_byte(input logic [7:0] v, output int strobes, output logic last_stb);
        logic s;
        strobes = 0;
        last_stb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            put_bit(v[i], s);
            if (s) strobes++;
            last_stb = s;
        end
    endtask

    task automatic t_reset_state();
        int n; logic l;
        chk(tx_bit == 1'b1, "R2 tx released after reset", tx_bit, 1);
        chk(sel_strobe == 1'b0, "R2 no strobe after reset", sel_strobe, 0);
        put_byte(8'hCC, n, l);
        chk(n == 0, "R2 command before first bus reset ignored", n, 0);
    endtask

    task automatic t_skip();
        int n; logic l, b, s;
        pulse_reset();
        put_byte(8'hCC, n, l);
        chk(l && n == 1, "R6 skip strobes after 8th bit", n, 1);
        @(negedge clk);
        chk(sel_strobe == 1'b0, "R10 strobe one cycle only", sel_strobe, 0);
        get_bit(b, s);
        put_bit(1'b0, s);
        chk(b == 1'b1 && !s, "R11 selected state silent", {b, s}, 2'b10);
    endtask

    task automatic t_read();
        int n; logic l, b, s;
        logic [63:0] got;
        int early = 0;
        pulse_reset();
        put_byte(8'h33, n, l);
        chk(n == 0, "R3 read command no early strobe", n, 0);
        for (int i = 0; i < 64; i++) begin
            get_bit(b, s);
            got[i] = b;
            if (s && i != 63) early++;
            if (i == 63) chk(s == 1'b1, "R4 strobe after 64th read slot", s, 1);
        end
        chk(got == exp_id, "R4 read identity order", got, exp_id);
        chk(early == 0, "R4 no strobe before last slot", early, 0);
        chk(got[7:0] == 8'h10 && got[55:8] == serial_no, "R1 family and serial fields",
            got[55:0], {serial_no, 8'h10});
        chk(got[63:56] == exp_id[63:56], "R1 crc byte", got[63:56], exp_id[63:56]);
    endtask

    task automatic t_match(input int bad_at, input string tag);
        int n, cnt; logic l, s, b, last;
        pulse_reset();
        put_byte(8'h55, n, l);
        cnt = 0;
        last = 1'b0;
        for (int i = 0; i < 64; i++) begin
            put_bit((i == bad_at) ? ~exp_id[i] : exp_id[i], s);
            if (s) cnt++;
            last = s;
        end
        if (bad_at < 0) begin
            chk(last && cnt == 1, {tag, " R5 full match strobes"}, cnt, 1);
        end else begin
            chk(cnt == 0, {tag, " R5 mismatch never strobes"}, cnt, 0);
            get_bit(b, s);
            chk(b == 1'b1, {tag, " R5 dropped slave released"}, b, 1);
        end
    endtask

    task automatic t_unknown();
        int n; logic l, b, s;
        pulse_reset();
        put_byte(8'h44, n, l);
        put_byte(8'hCC, n, l);
        chk(n == 0, "R3 unknown code ignores rest until reset", n, 0);
        get_bit(b, s);
        chk(b == 1'b1, "R11 ignoring state answers 1", b, 1);
        pulse_reset();
        put_byte(8'hCC, n, l);
        chk(n == 1, "R9 new reset recovers after unknown", n, 1);
    endtask

    // drop_at < 0: full pass; otherwise master picks the opposite bit there
    task automatic t_search(input logic [7:0] op, input int drop_at, input string tag);
        int n, errs, strobes; logic l, b, c, s;
        pulse_reset();
        put_byte(op, n, l);
        errs = 0;
        strobes = 0;
        for (int i = 0; i < 64; i++) begin
            get_bit(b, s); if (s) strobes++;
            get_bit(c, s); if (s) strobes++;
            if (drop_at >= 0 && i > drop_at) begin
                if (b != 1'b1 || c != 1'b1) errs++;
            end else if (b != exp_id[i] || c != ~exp_id[i]) begin
                errs++;
            end
            put_bit((i == drop_at) ? ~exp_id[i] : exp_id[i], s);
            if (s) strobes++;
        end
        chk(errs == 0, {tag, " R7 bit/complement/choice slots"}, errs, 0);
        chk(strobes == 0, {tag, " R7 search never selects"}, strobes, 0);
        get_bit(b, s);
        chk(b == 1'b1, {tag, " R7 silent after pass"}, b, 1);
    endtask

    task automatic t_alarm_clear();
        int n; logic l, b, c, s;
        alarm_flag = 1'b0;
        pulse_reset();
        put_byte(8'hEC, n, l);
        get_bit(b, s);
        get_bit(c, s);
        chk(b == 1'b1 && c == 1'b1, "R8 alarm search silent with flag clear", {b, c}, 2'b11);
    endtask

    task automatic t_abort();
        int n; logic l, b, s;
        pulse_reset();
        put_byte(8'h33, n, l);
        for (int i = 0; i < 10; i++) get_bit(b, s);
        pulse_reset();
        put_byte(8'hCC, n, l);
        chk(n == 1, "R9 reset aborts read", n, 1);
        pulse_reset();
        for (int i = 0; i < 4; i++) put_bit(1'b1, s);
        pulse_reset();
        put_byte(8'hCC, n, l);
        chk(n == 1, "R9 reset aborts partial command", n, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        exp_id = make_id(serial_no);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_skip();
        t_read();
        t_match(-1, "ok");
        t_match(40, "bit40");
        t_match(0, "bit0");
        t_unknown();
        t_search(8'hF0, -1, "full");
        t_search(8'hF0, 5, "drop5");
        t_alarm_clear();
        alarm_flag = 1'b1;
        t_search(8'hEC, -1, "R8 alarm set");
        alarm_flag = 1'b0;
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule